// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a single-data-rate SDRAM from power-up to normal operation. After reset it waits for a start pulse. It then holds the clock-enable low through the power-up delay and issues the initialization commands in a fixed order. Between commands it waits the required intervals and drives NOP on the pins.

The sequence runs as follows. A first NOP raises clock-enable. A precharge-all command follows, then a second NOP. The refresh interval is loaded first with a very short value and then with the operating value. The mode register is written through the address pins, and the block enters the normal state.

The refresh interval and a refresh-enable flag go to the memory controller next to the block. The interval counts in units of 16 clocks. The flag holds off auto-refresh until initialization is complete. A parallel 9-bit control word reports the current phase. The command pins follow the standard active-low encoding. Every wait time is a parameter in nanoseconds and is converted to clock cycles from the clock frequency when the design is elaborated.

Top module: `sdram_init_seq`

## Requirements
- R1: After a synchronous reset, and until start is sampled high, the outputs hold these values: cke 0, cs_n/ras_n/cas_n/we_n all 1, address 0, control word 0x000, refresh interval 0, refresh enable 0, done 0.
- R2: Once start is sampled, cke stays low and cs_n stays high for ceil(100 us x f) cycles (12500 at 125 MHz). In the next cycle, the first NOP is issued and cke rises.
- R3: Once cke is high it never falls before reset. Every cycle that carries no command drives NOP (cs_n 0, ras_n 1, cas_n 1, we_n 1).
- R4: Precharge-all is issued exactly once, ceil(10 us x f)+1 cycles after the first NOP. Its pins are cs_n 0, ras_n 0, cas_n 1, we_n 0, and address bit 10 is 1.
- R5: The second NOP comes ceil(1 us x f)+1 cycles after precharge-all. The same gap later, the refresh interval becomes floor(floor(200 ns x f)/16)+1 (2 at 125 MHz).
- R6: ceil(10 us x f)+1 cycles after the fast value, the refresh interval becomes floor(floor(15.625 us x f)/16)+1 (123 at 125 MHz).
- R7: The mode-register write is issued exactly once, ceil(10 us x f)+1 cycles after the operating refresh value. All four command pins are low, bank is 0, and the address carries CAS latency 3 on bits 6:4, 0 (sequential) on bit 3 and burst code 2 (length 4) on bits 2:0, giving 0x032.
- R8: The control word reads 0x183 from the first NOP until precharge-all, 0x103 from precharge-all until the second NOP, 0x183 again until the mode write, 0x083 from the mode write, and 0x002 in the normal state.
- R9: The normal state starts ceil(30 ns x f)+1 cycles (5 at 125 MHz) after the mode write. Refresh enable is 0 before that cycle and 1 from it on.
- R10: Done rises one cycle after the normal state is entered and stays high until reset.
- R11: A start pulse while the sequence runs or after it completes has no effect on timing, commands or done.
- R12: A reset asserted in the middle of the sequence returns every output to the R1 values at the next clock edge. The block then waits for a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begins the sequence when sampled high in the idle state |
| done_o | output | 1 | High from one cycle after the normal state, until reset |
| sd_cke_o | output | 1 | SDRAM clock enable |
| sd_cs_n_o | output | 1 | SDRAM chip select, active low |
| sd_ras_n_o | output | 1 | SDRAM row strobe, active low |
| sd_cas_n_o | output | 1 | SDRAM column strobe, active low |
| sd_we_n_o | output | 1 | SDRAM write enable, active low |
| sd_ba_o | output | BA_W | SDRAM bank address (always 0 during init) |
| sd_addr_o | output | ADDR_W | SDRAM address pins |
| ctl_word_o | output | 9 | Current phase control word |
| ref_interval_o | output | REF_W | Refresh interval in units of 16 clocks |
| ref_enable_o | output | 1 | Auto-refresh allowed |

## Verification
The bench drives one full sequence and checks every command, refresh update and flag change on the exact cycle it is due and on the cycle just before. A design that is one cycle off in any wait, loads the two refresh values in the wrong order, or writes the mode register before the operating refresh value fails these checks. A monitor counts how many times precharge-all and the mode write appear, and flags any cke drop or any malformed command between steps, so a sequencer that repeats a command or lets the pins glitch is caught. Start pulses during and after the sequence test that the block does not restart. A reset in the middle of the sequence tests that it abandons the run cleanly.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PWRUP, ST_NOP1, ST_W_NOP1, ST_PALL, ST_W_PALL,
    ST_NOP2, ST_W_NOP2, ST_RFAST, ST_W_RFAST, ST_RNORM, ST_W_RNORM,
    ST_MODE, ST_W_MODE, ST_NORMAL
  } seq_state_t;

  typedef struct packed {
    logic cke;
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_pins_t;

  localparam sd_pins_t PINS_OFF  = sd_pins_t'(5'b01111);
  localparam sd_pins_t PINS_NOP  = sd_pins_t'(5'b10111);
  localparam sd_pins_t PINS_PALL = sd_pins_t'(5'b10010);
  localparam sd_pins_t PINS_MODE = sd_pins_t'(5'b10000);

  localparam logic [8:0] CTL_NONE   = 9'h000;
  localparam logic [8:0] CTL_NOP    = 9'h183;
  localparam logic [8:0] CTL_PALL   = 9'h103;
  localparam logic [8:0] CTL_MODE   = 9'h083;
  localparam logic [8:0] CTL_NORMAL = 9'h002;

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          expired_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load_i)
      cnt_q <= len_i - CW'(1);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - CW'(1);
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/sdram_init_cmdenc.sv
module sdram_init_cmdenc
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int PALL_BIT    = 10,
  parameter int CAS_LAT     = 3,
  parameter int BURST_INTLV = 0,
  parameter int BURST_CODE  = 2
) (
  input  seq_state_t        st_i,
  output sd_pins_t          pins_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [8:0]        ctl_o
);

  localparam logic [ADDR_W-1:0] MODE_WORD =
    ADDR_W'((CAS_LAT << 4) | (BURST_INTLV << 3) | BURST_CODE);
  localparam logic [ADDR_W-1:0] PALL_WORD = ADDR_W'(1) << PALL_BIT;

  always_comb begin
    pins_o = PINS_NOP;
    addr_o = '0;
    ctl_o  = CTL_NOP;
    case (st_i)
      ST_IDLE, ST_PWRUP: begin
        pins_o = PINS_OFF;
        ctl_o  = CTL_NONE;
      end
      ST_PALL: begin
        pins_o = PINS_PALL;
        addr_o = PALL_WORD;
        ctl_o  = CTL_PALL;
      end
      ST_W_PALL: ctl_o = CTL_PALL;
      ST_MODE: begin
        pins_o = PINS_MODE;
        addr_o = MODE_WORD;
        ctl_o  = CTL_MODE;
      end
      ST_W_MODE: ctl_o = CTL_MODE;
      ST_NORMAL: ctl_o = CTL_NORMAL;
      default: ;
    endcase
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_MHZ        = 125,
  parameter int T_PWRUP_NS     = 100000,
  parameter int T_LONG_NS      = 10000,
  parameter int T_SHORT_NS     = 1000,
  parameter int T_MRD_NS       = 30,
  parameter int T_REF_FAST_NS  = 200,
  parameter int T_REF_NORM_NS  = 15625,
  parameter int ADDR_W         = 13,
  parameter int BA_W           = 2,
  parameter int REF_W          = 12,
  parameter int CAS_LAT        = 3,
  parameter int BURST_CODE     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  output logic              done_o,
  output logic              sd_cke_o,
  output logic              sd_cs_n_o,
  output logic              sd_ras_n_o,
  output logic              sd_cas_n_o,
  output logic              sd_we_n_o,
  output logic [BA_W-1:0]   sd_ba_o,
  output logic [ADDR_W-1:0] sd_addr_o,
  output logic [8:0]        ctl_word_o,
  output logic [REF_W-1:0]  ref_interval_o,
  output logic              ref_enable_o
);

  localparam int CYC_PWRUP = (T_PWRUP_NS * CLK_MHZ + 999) / 1000;
  localparam int CYC_LONG  = (T_LONG_NS  * CLK_MHZ + 999) / 1000;
  localparam int CYC_SHORT = (T_SHORT_NS * CLK_MHZ + 999) / 1000;
  localparam int CYC_MRD   = (T_MRD_NS   * CLK_MHZ + 999) / 1000;
  localparam int CYC_MAX   = (CYC_PWRUP > CYC_LONG) ? CYC_PWRUP : CYC_LONG;
  localparam int CW        = $clog2(CYC_MAX + 1);
  localparam int REF_FAST  = ((T_REF_FAST_NS * CLK_MHZ) / 1000) / 16 + 1;
  localparam int REF_NORM  = ((T_REF_NORM_NS * CLK_MHZ) / 1000) / 16 + 1;

  seq_state_t        state_q, state_d;
  logic              tmr_exp;
  logic [CW-1:0]     wait_len;
  sd_pins_t          pins_d;
  logic [ADDR_W-1:0] addr_d;
  logic [8:0]        ctl_d;

  // next-state: command states last one cycle, wait states until the timer expires
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_PWRUP;
      ST_PWRUP:   if (tmr_exp) state_d = ST_NOP1;
      ST_NOP1:    state_d = ST_W_NOP1;
      ST_W_NOP1:  if (tmr_exp) state_d = ST_PALL;
      ST_PALL:    state_d = ST_W_PALL;
      ST_W_PALL:  if (tmr_exp) state_d = ST_NOP2;
      ST_NOP2:    state_d = ST_W_NOP2;
      ST_W_NOP2:  if (tmr_exp) state_d = ST_RFAST;
      ST_RFAST:   state_d = ST_W_RFAST;
      ST_W_RFAST: if (tmr_exp) state_d = ST_RNORM;
      ST_RNORM:   state_d = ST_W_RNORM;
      ST_W_RNORM: if (tmr_exp) state_d = ST_MODE;
      ST_MODE:    state_d = ST_W_MODE;
      ST_W_MODE:  if (tmr_exp) state_d = ST_NORMAL;
      default:    state_d = ST_NORMAL;
    endcase
  end

  always_comb begin
    case (state_d)
      ST_PWRUP:                          wait_len = CW'(CYC_PWRUP);
      ST_W_NOP1, ST_W_RFAST, ST_W_RNORM: wait_len = CW'(CYC_LONG);
      ST_W_PALL, ST_W_NOP2:              wait_len = CW'(CYC_SHORT);
      ST_W_MODE:                         wait_len = CW'(CYC_MRD);
      default:                           wait_len = CW'(1);
    endcase
  end

  sdram_init_timer #(.CW(CW)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load_i    (state_d != state_q),
    .len_i     (wait_len),
    .expired_o (tmr_exp)
  );

  sdram_init_cmdenc #(
    .ADDR_W      (ADDR_W),
    .PALL_BIT    (10),
    .CAS_LAT     (CAS_LAT),
    .BURST_INTLV (0),
    .BURST_CODE  (BURST_CODE)
  ) u_enc (
    .st_i   (state_d),
    .pins_o (pins_d),
    .addr_o (addr_d),
    .ctl_o  (ctl_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q        <= ST_IDLE;
      sd_cke_o       <= 1'b0;
      sd_cs_n_o      <= 1'b1;
      sd_ras_n_o     <= 1'b1;
      sd_cas_n_o     <= 1'b1;
      sd_we_n_o      <= 1'b1;
      sd_addr_o      <= '0;
      ctl_word_o     <= CTL_NONE;
      ref_interval_o <= '0;
      ref_enable_o   <= 1'b0;
      done_o         <= 1'b0;
    end else begin
      state_q    <= state_d;
      sd_cke_o   <= pins_d.cke;
      sd_cs_n_o  <= pins_d.cs_n;
      sd_ras_n_o <= pins_d.ras_n;
      sd_cas_n_o <= pins_d.cas_n;
      sd_we_n_o  <= pins_d.we_n;
      sd_addr_o  <= addr_d;
      ctl_word_o <= ctl_d;
      if (state_d == ST_RFAST) ref_interval_o <= REF_W'(REF_FAST);
      if (state_d == ST_RNORM) ref_interval_o <= REF_W'(REF_NORM);
      ref_enable_o <= (state_d == ST_NORMAL);
      done_o       <= done_o | (state_q == ST_NORMAL);
    end
  end

  assign sd_ba_o = '0;

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int ADDR_W     = 13,
  parameter int BA_W       = 2,
  parameter int REF_W      = 12,
  parameter int REF_FAST   = 2,
  parameter int REF_NORM   = 123,
  parameter int CAS_LAT    = 3,
  parameter int BURST_CODE = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              done_o,
  input logic              sd_cke_o,
  input logic              sd_cs_n_o,
  input logic              sd_ras_n_o,
  input logic              sd_cas_n_o,
  input logic              sd_we_n_o,
  input logic [BA_W-1:0]   sd_ba_o,
  input logic [ADDR_W-1:0] sd_addr_o,
  input logic [8:0]        ctl_word_o,
  input logic [REF_W-1:0]  ref_interval_o,
  input logic              ref_enable_o
);

  localparam logic [ADDR_W-1:0] EXP_MODE = ADDR_W'((CAS_LAT << 4) | BURST_CODE);

  logic is_pall, is_mode;
  assign is_pall = !sd_cs_n_o && !sd_ras_n_o &&  sd_cas_n_o && !sd_we_n_o;
  assign is_mode = !sd_cs_n_o && !sd_ras_n_o && !sd_cas_n_o && !sd_we_n_o;

  a_r3_cke_holds: assert property (@(posedge clk) disable iff (rst)
    sd_cke_o |=> sd_cke_o);

  a_r2_no_cmd_cke_low: assert property (@(posedge clk) disable iff (rst)
    !sd_cke_o |-> sd_cs_n_o);

  a_r4_pall_a10: assert property (@(posedge clk) disable iff (rst)
    is_pall |-> sd_addr_o[10]);

  a_r8_pall_ctl: assert property (@(posedge clk) disable iff (rst)
    is_pall |-> (ctl_word_o == 9'h103));

  a_r7_mode_word: assert property (@(posedge clk) disable iff (rst)
    is_mode |-> (sd_addr_o == EXP_MODE && sd_ba_o == '0));

  a_r6_mode_after_norm_ref: assert property (@(posedge clk) disable iff (rst)
    is_mode |-> (ref_interval_o == REF_W'(REF_NORM)));

  a_r5_ref_values: assert property (@(posedge clk) disable iff (rst)
    !$stable(ref_interval_o) |->
      (ref_interval_o == REF_W'(REF_FAST) || ref_interval_o == REF_W'(REF_NORM)));

  a_r9_ref_en_normal: assert property (@(posedge clk) disable iff (rst)
    ref_enable_o |-> (ctl_word_o == 9'h002));

  a_r10_done_sticky: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o);

  a_r10_done_after_normal: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(ref_enable_o));

endmodule

bind sdram_init_seq sdram_init_chk #(
  .ADDR_W     (ADDR_W),
  .BA_W       (BA_W),
  .REF_W      (REF_W),
  .REF_FAST   (REF_FAST),
  .REF_NORM   (REF_NORM),
  .CAS_LAT    (CAS_LAT),
  .BURST_CODE (BURST_CODE)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .done_o         (done_o),
  .sd_cke_o       (sd_cke_o),
  .sd_cs_n_o      (sd_cs_n_o),
  .sd_ras_n_o     (sd_ras_n_o),
  .sd_cas_n_o     (sd_cas_n_o),
  .sd_we_n_o      (sd_we_n_o),
  .sd_ba_o        (sd_ba_o),
  .sd_addr_o      (sd_addr_o),
  .ctl_word_o     (ctl_word_o),
  .ref_interval_o (ref_interval_o),
  .ref_enable_o   (ref_enable_o)
);

// File: tb/sdram_init_seq_test.sv
`timescale 1ns/1ps
module sdram_init_seq_test;

  localparam int PWRUP = 12500;
  localparam int LONG  = 1250;
  localparam int SHORT = 125;
  localparam int MRD   = 4;
  localparam int RFAST = 2;
  localparam int RNORM = 123;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        done, cke, cs_n, ras_n, cas_n, we_n, ref_en;
  logic [1:0]  ba;
  logic [12:0] addr;
  logic [8:0]  ctl;
  logic [11:0] refi;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int pall_n, mode_n, bad_n, drop_n;
  bit seen_cke;
  bit finished = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_init_seq uut (
    .clk(clk), .rst(rst), .start_i(start), .done_o(done),
    .sd_cke_o(cke), .sd_cs_n_o(cs_n), .sd_ras_n_o(ras_n), .sd_cas_n_o(cas_n),
    .sd_we_n_o(we_n), .sd_ba_o(ba), .sd_addr_o(addr), .ctl_word_o(ctl),
    .ref_interval_o(refi), .ref_enable_o(ref_en)
  );

  // pin monitor: classify every cycle after cke rises
  always @(negedge clk) begin
    if (rst) begin
      pall_n = 0; mode_n = 0; bad_n = 0; drop_n = 0; seen_cke = 1'b0;
    end else begin
      if (seen_cke && !cke) drop_n++;
      if (cke) begin
        seen_cke = 1'b1;
        if ({cs_n, ras_n, cas_n, we_n} == 4'b0010) pall_n++;
        else if ({cs_n, ras_n, cas_n, we_n} == 4'b0000) mode_n++;
        else if ({cs_n, ras_n, cas_n, we_n} != 4'b0111) bad_n++;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic goto(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic pulse_start(output int s);
    @(negedge clk); start = 1'b1; s = cyc;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic check_idle(input string req);
    chk({req, " cke"}, cke, 0);
    chk({req, " cmd pins"}, {cs_n, ras_n, cas_n, we_n}, 4'b1111);
    chk({req, " addr"}, addr, 0);
    chk({req, " ctl"}, ctl, 0);
    chk({req, " refi"}, refi, 0);
    chk({req, " ref_en"}, ref_en, 0);
    chk({req, " done"}, done, 0);
  endtask

  task automatic t_reset_state();
    do_reset();
    @(negedge clk);
    check_idle("R1 reset");
    repeat (20) @(negedge clk);
    check_idle("R1 idle without start");
  endtask

  task automatic t_full_sequence();
    int s, t0, ps;
    do_reset();
    pulse_start(s);
    goto(s + 6000);
    chk("R2 cke low in power-up", cke, 0);
    chk("R2 cs_n high in power-up", cs_n, 1);
    goto(s + PWRUP);
    chk("R2 cke low last power-up cycle", cke, 0);
    t0 = s + PWRUP + 1;
    goto(t0);
    chk("R2 cke rises with first NOP", cke, 1);
    chk("R3 first NOP pins", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    chk("R8 ctl after first NOP", ctl, 'h183);
    goto(s + 13000);
    start = 1'b1; @(negedge clk); start = 1'b0;   // R11 mid-sequence pulse
    goto(t0 + LONG);
    chk("R3 NOP before precharge", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    goto(t0 + LONG + 1);
    chk("R4 precharge-all pins", {cs_n, ras_n, cas_n, we_n}, 4'b0010);
    chk("R4 precharge-all A10", addr[10], 1);
    chk("R8 ctl at precharge", ctl, 'h103);
    goto(t0 + LONG + 1 + SHORT);
    chk("R8 ctl before second NOP", ctl, 'h103);
    goto(t0 + LONG + SHORT + 2);
    chk("R8 ctl at second NOP", ctl, 'h183);
    goto(t0 + LONG + 2 * SHORT + 2);
    chk("R5 refi before fast load", refi, 0);
    goto(t0 + LONG + 2 * SHORT + 3);
    chk("R5 refi fast value", refi, RFAST);
    chk("R9 ref_en low during init", ref_en, 0);
    goto(t0 + 2 * LONG + 2 * SHORT + 3);
    chk("R6 refi still fast", refi, RFAST);
    goto(t0 + 2 * LONG + 2 * SHORT + 4);
    chk("R6 refi normal value", refi, RNORM);
    goto(t0 + 3 * LONG + 2 * SHORT + 4);
    chk("R7 NOP before mode write", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    goto(t0 + 3 * LONG + 2 * SHORT + 5);
    chk("R7 mode write pins", {cs_n, ras_n, cas_n, we_n}, 4'b0000);
    chk("R7 mode address 0x032", addr, 'h032);
    chk("R7 mode bank", ba, 0);
    chk("R8 ctl at mode write", ctl, 'h083);
    goto(t0 + 3 * LONG + 2 * SHORT + 5 + MRD);
    chk("R9 ref_en low last mode wait", ref_en, 0);
    chk("R10 done low before normal", done, 0);
    goto(t0 + 3 * LONG + 2 * SHORT + 6 + MRD);
    chk("R9 ref_en at normal", ref_en, 1);
    chk("R8 ctl at normal", ctl, 'h002);
    chk("R10 done not yet", done, 0);
    @(negedge clk);
    chk("R10 done one cycle after normal", done, 1);
    pulse_start(ps);                               // R11 post-completion pulse
    repeat (200) @(negedge clk);
    chk("R10 done sticky", done, 1);
    chk("R11 no restart pins NOP", {cke, cs_n, ras_n, cas_n, we_n}, 5'b10111);
    chk("R11 ctl still normal", ctl, 'h002);
    chk("R4 single precharge-all", pall_n, 1);
    chk("R7 single mode write", mode_n, 1);
    chk("R3 no malformed command", bad_n, 0);
    chk("R3 cke never dropped", drop_n, 0);
  endtask

  task automatic t_reset_mid();
    int s;
    do_reset();
    pulse_start(s);
    goto(s + PWRUP + 12);
    chk("R12 running before reset", cke, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_idle("R12 after mid reset");
    repeat (50) @(negedge clk);
    check_idle("R12 waits for new start");
  endtask

  initial begin
    t_reset_state();
    t_full_sequence();
    t_reset_mid();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule